// File: doc/BRIEF.md
# Processor Transaction Response Decoder

This block chooses how a second-level cache answers a transaction issued by its own processor. For each request it looks at the tag lookup result (miss, clean hit or dirty hit), the burst, cache-inhibit and write-through attributes, and the class of the transaction: read, write, or one of three address-only cache operations (flush, clean, kill). It also takes two flags saying whether the cycle just before was a snoop that hit the cache, of the read kind or of the write kind. Those flags change how a following burst write is handled.

The answer comes out as one-hot action strobes, registered, one clock after the request: start a line fill, claim the transaction with address and data acknowledges, update the cache, update and clear the dirty bit, invalidate, or retry with bus request and write the line back (followed by either invalidation or a dirty-bit reset). Cache-inhibited hits to a line that is present are resolved by invalidating the line, or by pushing it out first when it is dirty. The tag and data arrays and the bus timing belong to neighbouring logic.

Top module: `txn_resp_decoder`

## Requirements
- R1: A read (class 0) that misses (tag 2'b00, or the unused code 2'b11) with inhibit low and burst high raises `do_fill`; any other read miss raises no strobe.
- R2: A read that hits (tag 2'b01 clean or 2'b10 dirty) with inhibit low raises `do_claim`.
- R3: A read or write with inhibit high raises `do_invalidate` on a clean hit, `do_push_invalidate` on a dirty hit, and nothing on a miss, whatever the snoop flags and the other attributes.
- R4: A cacheable write (class 1) with write-through high, not a burst write after a snoop hit, raises `do_update` on a hit and nothing on a miss; a cacheable single-beat write with write-through low raises `do_claim` on a hit and nothing on a miss.
- R5: A cacheable burst write with write-through low and both snoop flags low raises `do_fill` on a miss, `do_claim` on a clean hit and `do_update_clean` on a dirty hit.
- R6: A cacheable burst write with `snp_wr_hit` high raises `do_invalidate` on a hit and nothing on a miss (no write allocate); `snp_wr_hit` wins when both snoop flags are high.
- R7: A cacheable burst write with only `snp_rd_hit` high raises `do_update_clean` on a hit and nothing on a miss.
- R8: A flush (class 2) raises `do_invalidate` on a clean hit and `do_push_invalidate` on a dirty hit.
- R9: A clean operation (class 3) raises nothing on a clean hit and `do_push_clean` on a dirty hit.
- R10: A kill (class 4) raises `do_invalidate` on either kind of hit.
- R11: At most one strobe is high in any cycle; strobes answer the request of the cycle before only; with `req_valid` low, for an address-only miss, or for class codes 5 to 7, all strobes are low.
- R12: While `rst_n` is low at a clock edge, all strobes are low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A processor transaction is presented this cycle |
| req_class | input | 3 | 0 read, 1 write, 2 flush, 3 clean, 4 kill, others reserved |
| tag_state | input | 2 | 00 miss, 01 clean hit, 10 dirty hit, 11 treated as miss |
| attr_burst | input | 1 | Burst transfer |
| attr_inhibit | input | 1 | Cache-inhibited transfer |
| attr_wthru | input | 1 | Write-through transfer |
| snp_rd_hit | input | 1 | The previous cycle was a snoop read that hit |
| snp_wr_hit | input | 1 | The previous cycle was a snoop write that hit |
| do_fill | output | 1 | Start a line fill |
| do_claim | output | 1 | Claim and give address and data acknowledges |
| do_update | output | 1 | Update the cached line |
| do_update_clean | output | 1 | Update the line and clear its dirty bit |
| do_invalidate | output | 1 | Invalidate the line |
| do_push_invalidate | output | 1 | Retry, request the bus, write back, then invalidate |
| do_push_clean | output | 1 | Retry, request the bus, write back, then reset dirty |

## Verification
The bench targets the orderings that decide between competing answers: inhibit against a preceding snoop hit, write-through against a burst after a snoop, and both snoop flags high at once. A design with the wrong order would claim or allocate on an inhibited access, or update a line a snoop write just made stale. Address-only misses, reserved class codes and dirty versus clean hits for clean operations are driven directly, since a slip there would push a clean line or fire a strobe for nothing. A random mix with a fixed seed covers the rest against a bench-side table.

// File: rtl/txn_rsp_pkg.sv
// Shared encodings for the processor transaction response decoder.
// Assumes the class and tag codes below are fixed by the neighbouring logic.
package txn_rsp_pkg;
    localparam int CLS_W  = 3;
    localparam int TAG_W  = 2;
    localparam int ACT_W  = 3;
    localparam int N_ACT  = 7;

    localparam logic [CLS_W-1:0] CLS_READ  = 3'd0;
    localparam logic [CLS_W-1:0] CLS_WRITE = 3'd1;
    localparam logic [CLS_W-1:0] CLS_FLUSH = 3'd2;
    localparam logic [CLS_W-1:0] CLS_CLEAN = 3'd3;
    localparam logic [CLS_W-1:0] CLS_KILL  = 3'd4;

    localparam logic [TAG_W-1:0] TAG_CLEAN = 2'b01;
    localparam logic [TAG_W-1:0] TAG_DIRTY = 2'b10;

    // Action code; value k (1..N_ACT) drives strobe bit k-1.
    typedef enum logic [ACT_W-1:0] {
        ACT_NONE       = 3'd0,
        ACT_FILL       = 3'd1,
        ACT_CLAIM      = 3'd2,
        ACT_UPDATE     = 3'd3,
        ACT_UPD_CLEAN  = 3'd4,
        ACT_INVAL      = 3'd5,
        ACT_PUSH_INVAL = 3'd6,
        ACT_PUSH_CLEAN = 3'd7
    } act_e;
endpackage

// File: rtl/rsp_rw_path.sv
// Decides the action for processor reads and writes.
// Assumes tag codes other than clean/dirty mean miss; a write-kind snoop hit
// outranks a read-kind one; cache-inhibit outranks every other attribute.
module rsp_rw_path
    import txn_rsp_pkg::*;
(
    input  logic             is_write,
    input  logic [TAG_W-1:0] tag,
    input  logic             burst,
    input  logic             inhibit,
    input  logic             wthru,
    input  logic             snp_rd,
    input  logic             snp_wr,
    output act_e             act
);
    logic hit_c, hit_d, hit;
    assign hit_c = (tag == TAG_CLEAN);
    assign hit_d = (tag == TAG_DIRTY);
    assign hit   = hit_c | hit_d;

    // Priority decode of the read/write answer.
    always_comb begin
        act = ACT_NONE;
        if (inhibit) begin
            if (hit_c)      act = ACT_INVAL;
            else if (hit_d) act = ACT_PUSH_INVAL;
        end else if (!is_write) begin
            if (hit)        act = ACT_CLAIM;
            else if (burst) act = ACT_FILL;
        end else if (burst && snp_wr) begin
            if (hit)        act = ACT_INVAL;
        end else if (burst && snp_rd) begin
            if (hit)        act = ACT_UPD_CLEAN;
        end else if (wthru) begin
            if (hit)        act = ACT_UPDATE;
        end else if (burst) begin
            if (hit_c)      act = ACT_CLAIM;
            else if (hit_d) act = ACT_UPD_CLEAN;
            else            act = ACT_FILL;
        end else begin
            if (hit)        act = ACT_CLAIM;
        end
    end

    always_comb begin
        assert (!(inhibit && (act == ACT_CLAIM || act == ACT_FILL))); // R3
    end
endmodule

// File: rtl/rsp_ao_path.sv
// Decides the action for address-only cache operations (flush, clean, kill).
// Assumes a miss on any of them needs no action.
module rsp_ao_path
    import txn_rsp_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    input  logic [TAG_W-1:0] tag,
    output act_e             act
);
    logic hit_c, hit_d;
    assign hit_c = (tag == TAG_CLEAN);
    assign hit_d = (tag == TAG_DIRTY);

    // Per-class answer for clean and dirty hits.
    always_comb begin
        act = ACT_NONE;
        unique case (cls)
            CLS_FLUSH: act = hit_d ? ACT_PUSH_INVAL : (hit_c ? ACT_INVAL : ACT_NONE);
            CLS_CLEAN: act = hit_d ? ACT_PUSH_CLEAN : ACT_NONE;
            CLS_KILL:  act = (hit_c || hit_d) ? ACT_INVAL : ACT_NONE;
            default:   act = ACT_NONE;
        endcase
    end
endmodule

// File: rtl/rsp_strobe_reg.sv
// Registers an action code as a one-hot strobe vector, one cycle later.
// Assumes action code k maps to strobe bit k-1 and code 0 to no strobe.
module rsp_strobe_reg
    import txn_rsp_pkg::*;
#(
    parameter int NA = N_ACT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  act_e          act,
    output logic [NA-1:0] strobe
);
    logic [ACT_W-1:0] code;
    assign code = act;

    for (genvar i = 0; i < NA; i++) begin : g_bit
        // One flop per action: set when this cycle's valid code selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) strobe[i] <= 1'b0;
            else        strobe[i] <= valid && (code == ACT_W'(i + 1));
        end
    end
endmodule

// File: rtl/txn_resp_decoder.sv
// Top: picks the read/write or address-only answer for a processor request
// and presents it as registered one-hot strobes one cycle later.
// Assumes request inputs are stable for the cycle req_valid is high.
module txn_resp_decoder
    import txn_rsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [CLS_W-1:0] req_class,
    input  logic [TAG_W-1:0] tag_state,
    input  logic             attr_burst,
    input  logic             attr_inhibit,
    input  logic             attr_wthru,
    input  logic             snp_rd_hit,
    input  logic             snp_wr_hit,
    output logic             do_fill,
    output logic             do_claim,
    output logic             do_update,
    output logic             do_update_clean,
    output logic             do_invalidate,
    output logic             do_push_invalidate,
    output logic             do_push_clean
);
    act_e rw_act, ao_act, sel_act;
    logic is_rw;
    logic [N_ACT-1:0] strobe;

    assign is_rw = (req_class == CLS_READ) || (req_class == CLS_WRITE);

    rsp_rw_path u_rw (
        .is_write (req_class == CLS_WRITE),
        .tag      (tag_state),
        .burst    (attr_burst),
        .inhibit  (attr_inhibit),
        .wthru    (attr_wthru),
        .snp_rd   (snp_rd_hit),
        .snp_wr   (snp_wr_hit),
        .act      (rw_act)
    );

    rsp_ao_path u_ao (
        .cls (req_class),
        .tag (tag_state),
        .act (ao_act)
    );

    // Select the path that owns this transaction class.
    always_comb sel_act = is_rw ? rw_act : ao_act;

    rsp_strobe_reg #(.NA(N_ACT)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (req_valid),
        .act    (sel_act),
        .strobe (strobe)
    );

    assign do_fill            = strobe[0];
    assign do_claim           = strobe[1];
    assign do_update          = strobe[2];
    assign do_update_clean    = strobe[3];
    assign do_invalidate      = strobe[4];
    assign do_push_invalidate = strobe[5];
    assign do_push_clean      = strobe[6];

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_fill, do_claim, do_update, do_update_clean,
                  do_invalidate, do_push_invalidate, do_push_clean})); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(do_fill || do_claim || do_update || do_update_clean ||
                         do_invalidate || do_push_invalidate || do_push_clean)); // R11
    AST_AO_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !is_rw && tag_state != TAG_CLEAN && tag_state != TAG_DIRTY)
        |=> !(do_fill || do_claim || do_update || do_update_clean ||
              do_invalidate || do_push_invalidate || do_push_clean)); // R11
    AST_INHIBIT_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_rw && attr_inhibit)
        |=> !(do_fill || do_claim || do_update || do_update_clean)); // R3
    AST_SNOOP_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class == CLS_WRITE && !attr_inhibit && attr_burst &&
         (snp_rd_hit || snp_wr_hit)) |=> !do_fill); // R6
    AST_KILL_HIT_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class == CLS_KILL &&
         (tag_state == TAG_CLEAN || tag_state == TAG_DIRTY)) |=> do_invalidate); // R10
endmodule

// File: tb/sim_txn_resp_decoder.sv
// Bench: directed corner cases plus seeded random requests, checked against
// a bench-side decision table.
module sim_txn_resp_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_class = 3'd0;
    logic [1:0] tag_state = 2'd0;
    logic       attr_burst = 1'b0, attr_inhibit = 1'b0, attr_wthru = 1'b0;
    logic       snp_rd_hit = 1'b0, snp_wr_hit = 1'b0;
    logic       do_fill, do_claim, do_update, do_update_clean;
    logic       do_invalidate, do_push_invalidate, do_push_clean;
    int         n_chk = 0, n_err = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    txn_resp_decoder u0 (.*);

    function automatic logic [6:0] got();
        return {do_push_clean, do_push_invalidate, do_invalidate,
                do_update_clean, do_update, do_claim, do_fill};
    endfunction

    // Expected strobe vector: bit0 fill, 1 claim, 2 update, 3 update+clean,
    // 4 invalidate, 5 push+invalidate, 6 push+clean.
    function automatic logic [6:0] expect_vec(input logic [2:0] c, input logic [1:0] t,
            input logic b, input logic ci, input logic wt, input logic sr, input logic sw);
        bit cl = (t == 2'b01), dy = (t == 2'b10);
        bit h  = cl || dy;
        case (c)
            3'd0: begin
                if (ci)  return cl ? 7'h10 : (dy ? 7'h20 : 7'h00);
                if (h)   return 7'h02;
                return b ? 7'h01 : 7'h00;
            end
            3'd1: begin
                if (ci)        return cl ? 7'h10 : (dy ? 7'h20 : 7'h00);
                if (b && sw)   return h ? 7'h10 : 7'h00;
                if (b && sr)   return h ? 7'h08 : 7'h00;
                if (wt)        return h ? 7'h04 : 7'h00;
                if (b)         return cl ? 7'h02 : (dy ? 7'h08 : 7'h01);
                return h ? 7'h02 : 7'h00;
            end
            3'd2: return cl ? 7'h10 : (dy ? 7'h20 : 7'h00);
            3'd3: return dy ? 7'h40 : 7'h00;
            3'd4: return h ? 7'h10 : 7'h00;
            default: return 7'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] c, input logic b, input logic ci,
            input logic wt, input logic sr, input logic sw);
        if (c > 3'd4) return "R11";
        if (c == 3'd2) return "R8";
        if (c == 3'd3) return "R9";
        if (c == 3'd4) return "R10";
        if (ci) return "R3";
        if (c == 3'd0) return "R1/R2";
        if (b && sw) return "R6";
        if (b && sr) return "R7";
        if (wt || !b) return "R4";
        return "R5";
    endfunction

    task automatic check(input string req, input logic [6:0] exp);
        n_chk++;
        if (got() !== exp) begin
            n_err++;
            $display("FAIL %s: strobes=%b expected=%b", req, got(), exp);
        end
    endtask

    // Present one request at a falling edge, check one cycle after capture.
    task automatic issue(input logic [2:0] c, input logic [1:0] t, input logic b,
            input logic ci, input logic wt, input logic sr, input logic sw);
        req_valid = 1'b1; req_class = c; tag_state = t;
        attr_burst = b; attr_inhibit = ci; attr_wthru = wt;
        snp_rd_hit = sr; snp_wr_hit = sw;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag_of(c, b, ci, wt, sr, sw), expect_vec(c, t, b, ci, wt, sr, sw));
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: done=0 expected=1");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int seed = 7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check("R12", 7'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", 7'h00);
        // Directed corners.
        issue(3'd0, 2'b00, 1, 0, 0, 0, 0);  // R1 burst read miss -> fill
        issue(3'd0, 2'b11, 0, 0, 0, 0, 0);  // R1 single read miss -> none
        issue(3'd0, 2'b10, 1, 0, 0, 0, 0);  // R2 read hit dirty -> claim
        issue(3'd0, 2'b01, 1, 1, 0, 0, 0);  // R3 inhibited read clean -> inval
        issue(3'd1, 2'b10, 1, 1, 0, 1, 1);  // R3 inhibit beats snoop
        issue(3'd1, 2'b01, 0, 0, 1, 0, 0);  // R4 write-through hit -> update
        issue(3'd1, 2'b00, 1, 0, 0, 0, 0);  // R5 burst write miss -> fill
        issue(3'd1, 2'b10, 1, 0, 0, 0, 0);  // R5 dirty -> update+clean
        issue(3'd1, 2'b01, 1, 0, 1, 1, 1);  // R6 both snoops, write wins
        issue(3'd1, 2'b00, 1, 0, 0, 0, 1);  // R6 no allocate
        issue(3'd1, 2'b01, 1, 0, 1, 1, 0);  // R7 over write-through
        issue(3'd2, 2'b10, 0, 0, 0, 0, 0);  // R8 flush dirty
        issue(3'd3, 2'b01, 0, 0, 0, 0, 0);  // R9 clean on clean hit -> none
        issue(3'd3, 2'b10, 0, 0, 0, 0, 0);  // R9 dirty -> push+clean
        issue(3'd4, 2'b10, 0, 0, 0, 0, 0);  // R10 kill
        issue(3'd4, 2'b00, 0, 0, 0, 0, 0);  // R11 address-only miss
        issue(3'd6, 2'b10, 1, 0, 0, 0, 0);  // R11 reserved class
        // Constrained random mix, classes 0..7 with bias to read/write.
        for (int k = 0; k < 3000; k++) begin
            logic [2:0] c;
            c = ($urandom % 4 < 2) ? 3'($urandom % 2) : 3'($urandom % 8);
            issue(c, 2'($urandom), 1'($urandom), 1'($urandom % 4 == 0),
                  1'($urandom), 1'($urandom % 3 == 0), 1'($urandom % 3 == 0));
            if ($urandom % 5 == 0) begin
                @(negedge clk);
                check("R11", 7'h00);
            end
        end
        // Reset while a strobe is due.
        req_valid = 1'b1; req_class = 3'd4; tag_state = 2'b01; rst_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R12", 7'h00);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule